// File: doc/BRIEF.md
# 10 Mbps receive nibble framer

This block sits between a 10 Mbps Manchester decoder and the receive side of an MII. It takes one recovered bit per strobe, plus a line-activity level that stays high while a frame is on the wire. From these it produces `rxd`, `rx_dv` and `crs`.

The block hunts for a run of alternating bits and qualifies it as a preamble, which raises carrier sense. It then waits for the first pair of consecutive ones, which marks the start-of-frame delimiter. From that point it packs the frame body into nibbles, least-significant bit first. When line activity falls, it flushes the held nibble and any dribble bits, then closes the frame. No scrambling is applied anywhere on this path.

Two configuration inputs change the behaviour:
- `cfg_pass_pre` selects whether preamble nibbles are stripped or passed to the MAC.
- `cfg_crs_sync` selects whether carrier sense drops at end of frame or together with `rx_dv`.

Every output is a register. The outputs change only on nibble events: qualification, the delimiter, a completed nibble, or a flush step.

Top module: `rx10_mii_framer`

## Requirements
- R1: After a synchronous reset, and whenever neither `crs` nor `rx_dv` is high, `rxd`, `rx_dv` and `crs` read 0.
- R2: `crs` rises on the cycle after the bit that completes PRE_MIN consecutive alternating bits while `line_act` is high; a repeated bit restarts the count, and a shorter run never raises `crs`.
- R3: With `cfg_pass_pre`=0, `rx_dv` stays low through the preamble. It rises on the cycle after the second of two consecutive 1 bits, with `rxd`=0x5. `rxd` becomes 0xD on the cycle after the fourth bit that follows.
- R4: With `cfg_pass_pre`=1, `rx_dv` and `crs` rise together at qualification, with `rxd`=0x5 held through the preamble and delimiter.
- R5: Body bits are packed least-significant first (the first bit received lands in `rxd[0]`). Body nibble k appears on the cycle after the fourth bit of nibble k+1.
- R6: On the cycle after `line_act` is sampled low during the body, `rxd` shows the last held nibble (0xD if no whole body nibble arrived).
- R7: If the body ends with 1 to 4 bits past the last whole byte, those bits leave as one nibble. When 1 to 3 bits remain, they follow the held nibble one cycle later, with the unused upper positions set to 1.
- R8: If 5 to 7 bits remain past the last whole byte, only the first whole nibble of them is sent and the partial remainder is discarded.
- R9: If `line_act` falls after qualification but before the delimiter, `crs` and `rx_dv` clear on the next cycle. In strip mode, `rx_dv` never rises for that frame.
- R10: With `cfg_crs_sync`=0, `crs` falls on the cycle after `line_act` is sampled low during the body. With `cfg_crs_sync`=1, `crs` falls on the same cycle as `rx_dv`, one cycle after the last flushed nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_act | input | 1 | High while a frame is being received; its fall marks end of frame |
| bit_vld | input | 1 | One-cycle strobe marking `bit_in` valid |
| bit_in | input | 1 | Decoded serial bit |
| cfg_pass_pre | input | 1 | 1 passes the preamble to the MII, 0 strips it |
| cfg_crs_sync | input | 1 | 1 aligns the fall of `crs` with the fall of `rx_dv` |
| rxd | output | 4 | Receive nibble |
| rx_dv | output | 1 | Receive data valid |
| crs | output | 1 | Carrier sense |

## Verification
The assertions assume that both configuration inputs hold steady for the whole of a frame. They also assume that `line_act` stays low for at least three cycles after it falls, so that the flush and close steps finish before a new frame can start. The stimulus changes the configuration only while the line has been idle for several cycles, and it always leaves six idle cycles between frames. Bit strobes are spaced one, two or three cycles apart and arrive only while `line_act` is high.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int NIB_W = 4;
  localparam logic [NIB_W-1:0] NIB_PRE = 4'h5;
  localparam logic [NIB_W-1:0] NIB_SFD = 4'hD;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_QUAL,
    ST_DATA,
    ST_TAIL,
    ST_CLOSE
  } rxf_state_e;
endpackage

// File: rtl/rxf_pre_detect.sv
module rxf_pre_detect #(
  parameter int PRE_MIN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic line_act,
  input  logic bit_vld,
  input  logic bit_in,
  output logic qual_hit,
  output logic pair_hi,
  output logic pair_lo
);
  localparam int CW = $clog2(PRE_MIN + 1);

  logic [CW-1:0] run_q, run_d;
  logic prev_q, have_q;
  logic stb;

  assign stb = line_act & bit_vld;

  always_comb begin
    if (!have_q || bit_in == prev_q) run_d = CW'(1);
    else if (run_q >= CW'(PRE_MIN)) run_d = CW'(PRE_MIN);
    else run_d = run_q + 1'b1;
  end

  assign qual_hit = stb && (run_d == CW'(PRE_MIN));
  assign pair_hi  = stb && have_q && prev_q && bit_in;
  assign pair_lo  = stb && have_q && !prev_q && !bit_in;

  always_ff @(posedge clk) begin
    if (rst || !line_act) begin
      run_q  <= '0;
      prev_q <= 1'b0;
      have_q <= 1'b0;
    end else if (bit_vld) begin
      run_q  <= run_d;
      prev_q <= bit_in;
      have_q <= 1'b1;
    end
  end

  assert_run_bound_R2: assert property (@(posedge clk) disable iff (rst)
    run_q <= CW'(PRE_MIN));
endmodule

// File: rtl/rxf_nib_pack.sv
module rxf_nib_pack
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             data_stb,
  input  logic             bit_in,
  output logic             nib_done,
  output logic [NIB_W-1:0] hold,
  output logic [NIB_W-1:0] tail_nib,
  output logic             send_tail
);
  localparam int PW = $clog2(NIB_W);

  logic [PW-1:0]    pos_q;
  logic [NIB_W-1:0] acc_q;
  logic             odd_q;
  logic [NIB_W-1:0] lo_mask;

  assign nib_done  = data_stb && (pos_q == PW'(NIB_W - 1));
  assign tail_nib  = acc_q;
  assign send_tail = (pos_q != '0) && !odd_q;
  assign lo_mask   = NIB_W'((1 << pos_q) - 1);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      pos_q <= '0;
      acc_q <= '1;
      hold  <= start ? NIB_SFD : '0;
      odd_q <= 1'b0;
    end else if (data_stb) begin
      if (pos_q == PW'(NIB_W - 1)) begin
        hold  <= {bit_in, acc_q[NIB_W-2:0]};
        acc_q <= '1;
        pos_q <= '0;
        odd_q <= ~odd_q;
      end else begin
        acc_q[pos_q] <= bit_in;
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assert_pad_ones_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_q | lo_mask) == '1);
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             line_act,
  input  logic             bit_vld,
  input  logic             cfg_pass_pre,
  input  logic             cfg_crs_sync,
  input  logic             qual_hit,
  input  logic             pair_hi,
  input  logic             pair_lo,
  input  logic             nib_done,
  input  logic [NIB_W-1:0] hold,
  input  logic [NIB_W-1:0] tail_nib,
  input  logic             send_tail,
  output logic             start,
  output logic             data_stb,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_dv,
  output logic             crs
);
  rxf_state_e state;

  assign start    = (state == ST_QUAL) && pair_hi;
  assign data_stb = (state == ST_DATA) && line_act && bit_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_HUNT;
      rxd   <= '0;
      rx_dv <= 1'b0;
      crs   <= 1'b0;
    end else begin
      case (state)
        ST_HUNT: begin
          if (qual_hit) begin
            state <= ST_QUAL;
            crs   <= 1'b1;
            if (cfg_pass_pre) begin
              rx_dv <= 1'b1;
              rxd   <= NIB_PRE;
            end
          end
        end
        ST_QUAL: begin
          if (!line_act || pair_lo) begin
            state <= ST_HUNT;
            crs   <= 1'b0;
            rx_dv <= 1'b0;
            rxd   <= '0;
          end else if (pair_hi) begin
            state <= ST_DATA;
            rx_dv <= 1'b1;
            rxd   <= NIB_PRE;
          end
        end
        ST_DATA: begin
          if (!line_act) begin
            rxd   <= hold;
            state <= send_tail ? ST_TAIL : ST_CLOSE;
            if (!cfg_crs_sync) crs <= 1'b0;
          end else if (nib_done) begin
            rxd <= hold;
          end
        end
        ST_TAIL: begin
          rxd   <= tail_nib;
          state <= ST_CLOSE;
        end
        default: begin
          state <= ST_HUNT;
          rx_dv <= 1'b0;
          crs   <= 1'b0;
          rxd   <= '0;
        end
      endcase
    end
  end

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (!crs && !rx_dv) |-> (rxd == '0));
  assert_dv_after_crs_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_dv) && !cfg_pass_pre) |-> $past(crs));
  assert_sfd_nibble_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_dv) && !cfg_pass_pre) |-> (rxd == NIB_PRE));
  assert_pass_together_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_dv) && cfg_pass_pre && $past(state) == ST_HUNT) |-> $rose(crs));
  assert_crs_sync_R10: assert property (@(posedge clk) disable iff (rst)
    ($fell(crs) && cfg_crs_sync && $past(cfg_crs_sync)) |-> !rx_dv);
endmodule

// File: rtl/rx10_mii_framer.sv
module rx10_mii_framer #(
  parameter int PRE_MIN = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_act,
  input  logic       bit_vld,
  input  logic       bit_in,
  input  logic       cfg_pass_pre,
  input  logic       cfg_crs_sync,
  output logic [3:0] rxd,
  output logic       rx_dv,
  output logic       crs
);
  logic qual_hit, pair_hi, pair_lo;
  logic start, data_stb, nib_done, send_tail;
  logic [3:0] hold, tail_nib;

  rxf_pre_detect #(.PRE_MIN(PRE_MIN)) u_pre (
    .clk(clk), .rst(rst), .line_act(line_act), .bit_vld(bit_vld),
    .bit_in(bit_in), .qual_hit(qual_hit), .pair_hi(pair_hi), .pair_lo(pair_lo)
  );

  rxf_nib_pack u_pack (
    .clk(clk), .rst(rst), .start(start), .data_stb(data_stb), .bit_in(bit_in),
    .nib_done(nib_done), .hold(hold), .tail_nib(tail_nib), .send_tail(send_tail)
  );

  rxf_ctrl u_ctrl (
    .clk(clk), .rst(rst), .line_act(line_act), .bit_vld(bit_vld),
    .cfg_pass_pre(cfg_pass_pre), .cfg_crs_sync(cfg_crs_sync),
    .qual_hit(qual_hit), .pair_hi(pair_hi), .pair_lo(pair_lo),
    .nib_done(nib_done), .hold(hold), .tail_nib(tail_nib), .send_tail(send_tail),
    .start(start), .data_stb(data_stb), .rxd(rxd), .rx_dv(rx_dv), .crs(crs)
  );
endmodule

// File: tb/rx10_mii_framer_test.sv
module rx10_mii_framer_test;
  localparam int PRE = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_act = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
  logic cfg_pass_pre = 1'b0, cfg_crs_sync = 1'b0;
  logic [3:0] rxd;
  logic rx_dv, crs;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rx10_mii_framer #(.PRE_MIN(PRE)) uut (
    .clk(clk), .rst(rst), .line_act(line_act), .bit_vld(bit_vld), .bit_in(bit_in),
    .cfg_pass_pre(cfg_pass_pre), .cfg_crs_sync(cfg_crs_sync),
    .rxd(rxd), .rx_dv(rx_dv), .crs(crs)
  );

  // behavioural reference: 0 hunt, 1 qualified, 2 body, 3 tail, 4 close
  int m_st = 0, m_run = 0;
  bit m_prv = 0, m_hv = 0;
  bit m_q[$];
  logic [3:0] e_rxd = 0, m_pad = 0;
  bit e_dv = 0, e_crs = 0;
  string tag = "R1";

  function automatic logic [3:0] nib_at(int k);
    return {m_q[4*k+3], m_q[4*k+2], m_q[4*k+1], m_q[4*k]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_run = 0; m_hv = 0; m_prv = 0;
      e_rxd = 0; e_dv = 0; e_crs = 0; tag = "R1";
    end else begin
      int nr, f, r;
      bit s;
      s = line_act && bit_vld;
      nr = (!m_hv || bit_in == m_prv) ? 1 : ((m_run + 1 > PRE) ? PRE : m_run + 1);
      case (m_st)
        0: if (s && nr == PRE) begin
             m_st = 1; e_crs = 1;
             if (cfg_pass_pre) begin e_dv = 1; e_rxd = 4'h5; tag = "R4"; end
             else tag = "R2";
           end
        1: if (!line_act || (s && m_hv && !m_prv && !bit_in)) begin
             m_st = 0; e_crs = 0; e_dv = 0; e_rxd = 0; tag = "R9";
           end else if (s && m_hv && m_prv && bit_in) begin
             m_st = 2; e_dv = 1; e_rxd = 4'h5; m_q.delete(); tag = "R3";
           end
        2: if (!line_act) begin
             f = m_q.size() / 4; r = m_q.size() % 4;
             e_rxd = (f == 0) ? 4'hD : nib_at(f - 1);
             if (!cfg_crs_sync) e_crs = 0;
             m_pad = 4'hF;
             for (int i = 0; i < r; i++) m_pad[i] = m_q[4*f + i];
             if (r > 0 && f % 2 == 0) begin m_st = 3; tag = "R7"; end
             else begin m_st = 4; tag = (r > 0) ? "R8" : "R6"; end
           end else if (s) begin
             m_q.push_back(bit_in);
             if (m_q.size() % 4 == 0) begin
               e_rxd = (m_q.size() == 4) ? 4'hD : nib_at(m_q.size() / 4 - 2);
               tag = (m_q.size() == 4) ? "R3" : "R5";
             end
           end
        3: begin e_rxd = m_pad; m_st = 4; tag = "R7"; end
        default: begin m_st = 0; e_dv = 0; e_crs = 0; e_rxd = 0; tag = "R10"; end
      endcase
      if (!line_act) begin m_run = 0; m_hv = 0; m_prv = 0; end
      else if (bit_vld) begin m_run = nr; m_prv = bit_in; m_hv = 1; end
    end
  end

  bit seen_dv = 0, seen_crs = 0;
  always @(negedge clk) begin
    if (!finished) begin
      total++;
      if (rxd !== e_rxd || rx_dv !== e_dv || crs !== e_crs) begin
        bad++;
        $display("FAIL %s t=%0t actual rxd=%h dv=%b crs=%b expected rxd=%h dv=%b crs=%b",
                 tag, $time, rxd, rx_dv, crs, e_rxd, e_dv, e_crs);
      end
      if (rx_dv === 1'b1) seen_dv = 1;
      if (crs === 1'b1) seen_crs = 1;
    end
  end

  task automatic check_bit(string req, bit act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic send_bit(bit b, int gap);
    bit_in = b; bit_vld = 1;
    @(negedge clk);
    bit_vld = 0;
    repeat (gap - 1) @(negedge clk);
  endtask

  // noise ones, then pre alternating bits from st, optional 1,1, then body bits
  task automatic frame(int noise, bit st, int pre, bit sfd, int nbits, int gap);
    seen_dv = 0; seen_crs = 0;
    line_act = 1;
    @(negedge clk);
    for (int i = 0; i < noise; i++) send_bit(1'b1, gap);
    for (int i = 0; i < pre; i++) send_bit((i % 2 == 0) ? st : !st, gap);
    if (sfd) begin send_bit(1'b1, gap); send_bit(1'b1, gap); end
    for (int i = 0; i < nbits; i++) send_bit(1'($urandom_range(0, 1)), gap);
    line_act = 0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      finished = 1;
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check_bit("R1 reset dv", rx_dv, 0);
    check_bit("R1 reset crs", crs, 0);
    rst = 0;
    @(negedge clk);
    // strip mode, various dribble counts (R3, R5, R6, R7, R8, R10)
    frame(0, 1, 20, 1, 24, 2);
    frame(0, 1, 22, 1, 26, 1);
    frame(0, 1, 20, 1, 28, 3);
    frame(0, 1, 24, 1, 30, 2);
    frame(0, 1, 20, 1, 33, 1);
    frame(0, 1, 20, 1, 39, 2);
    frame(0, 1, 20, 1, 0, 2);
    frame(0, 0, 23, 1, 16, 2);
    check_bit("R3 strip frame raised dv", seen_dv, 1);
    // R2: short run never raises carrier
    frame(0, 1, PRE - 1, 0, 0, 2);
    check_bit("R2 short preamble crs", seen_crs, 0);
    // R2: repeated bits before the run restart the count
    frame(3, 1, 20, 1, 20, 2);
    // R9: drop before delimiter in strip mode
    frame(0, 1, 20, 0, 0, 2);
    check_bit("R9 aborted crs seen", seen_crs, 1);
    check_bit("R9 aborted dv", seen_dv, 0);
    // pass mode with aligned carrier drop (R4, R10)
    cfg_pass_pre = 1; cfg_crs_sync = 1;
    repeat (3) @(negedge clk);
    frame(0, 1, 20, 1, 27, 2);
    frame(0, 1, 22, 1, 37, 1);
    frame(0, 1, 20, 1, 32, 3);
    frame(0, 1, 20, 0, 0, 2);
    check_bit("R4 pass abort dv", seen_dv, 1);
    cfg_crs_sync = 0;
    repeat (3) @(negedge clk);
    frame(0, 1, 20, 1, 45, 2);
    cfg_pass_pre = 0; cfg_crs_sync = 1;
    repeat (3) @(negedge clk);
    frame(0, 1, 20, 1, 34, 2);
    frame(0, 1, 20, 1, 44, 1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule